// File: doc/BRIEF.md
# Dual-Mode Latch/Register Bus Driver

This block carries a word from an input bus to an output bus through one storage bit per lane. A mode input picks how that storage behaves. With `pass_en` high the path is transparent: the output follows the input, and the storage tracks it. With `pass_en` low the storage becomes edge-triggered. It loads the input word on each rising transition of the capture strobe `cap_clk` and holds the word at all other times. An active-low output disable, `drive_n`, releases every output lane. The output is modelled as a data vector plus a per-lane enable vector. A pad ring or an inout wrapper turns these into a real tri-state bus.

The block runs in a system clock domain `clk`. The capture strobe is treated as a synchronous input, and its rising edges are detected against its value in the previous `clk` cycle. When the mode input falls, the storage keeps the word it last passed through. This holds whatever level the strobe has at that moment. The next rising strobe edge replaces that word. The held word is brought out on `held_q` so that an environment can see it while the outputs are released.

Top module: `univ_bus_driver`

## Requirements
- R1: While `drive_n` is 1, every bit of `y_en` is 0, whatever `pass_en`, `cap_clk` and `a_in` do.
- R2: While `drive_n` is 0, every bit of `y_en` is 1.
- R3: While `pass_en` is 1, `y_val` equals `a_in` in the same cycle, and transitions of `cap_clk` have no effect.
- R4: While `pass_en` is 0, a cycle in which `cap_clk` is sampled 1 after having been 0 in the previous cycle loads `a_in` into `held_q` at that clock edge. `y_val` then shows the loaded word.
- R5: While `pass_en` is 0 and `cap_clk` is held at either level, `held_q` does not change and `y_val` equals `held_q`, whatever `a_in` does.
- R6: In the first cycle with `pass_en` at 0 after it was 1, `held_q` equals the `a_in` of the last transparent cycle. This holds whether `cap_clk` is high or low at that moment.
- R7: The storage keeps working while `drive_n` is 1. Setting `drive_n` back to 0 shows the held word without a new capture.
- R8: Reset (`rst_n` low) clears `held_q` to zero. A `cap_clk` already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Input data word |
| pass_en | input | 1 | 1 = transparent mode, 0 = edge-capture mode |
| cap_clk | input | 1 | Capture strobe, synchronous to `clk` |
| drive_n | input | 1 | Active-low output enable; 1 releases all lanes |
| y_val | output | W | Value driven on each lane when enabled |
| y_en | output | W | Per-lane drive enable |
| held_q | output | W | Word currently held in the storage |

## Verification
On every cycle, the assertions check the enable vector against `drive_n`, and the transparent output against the input. They also check that edge-capture mode shows the stored word. The storage is checked as well: it loads on a detected strobe rise, stays unchanged otherwise, and holds the last transparent word when the mode input falls. The bench scenarios show the rest: a mode fall with the strobe high and then low, capture continuing while the outputs are released, the held word reappearing when the outputs are enabled again, and a reset taken with a non-zero word stored.

// File: rtl/ubd_pkg.sv
package ubd_pkg;

  // Next state of one storage bit: track in transparent mode, load on a
  // detected strobe rise in capture mode, otherwise hold.
  function automatic logic next_bit(input logic pass, input logic rise,
                                    input logic d, input logic q);
    if (pass || rise) return d;
    return q;
  endfunction

  // Value seen at one lane: input when transparent, storage otherwise.
  function automatic logic view_bit(input logic pass, input logic d,
                                    input logic q);
    return pass ? d : q;
  endfunction

endpackage

// File: rtl/ubd_edge.sv
module ubd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  // Reset to 1 so a strobe already high at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/ubd_cell.sv
module ubd_cell
  import ubd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pass,
  input  logic rise,
  input  logic d,
  output logic q,
  output logic y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= next_bit(pass, rise, d, q);
  end

  assign y = view_bit(pass, d, q);
endmodule

// File: rtl/ubd_drive.sv
module ubd_drive #(
  parameter int W = 18
) (
  input  logic         drive_n,
  output logic [W-1:0] en
);
  assign en = {W{~drive_n}};
endmodule

// File: rtl/univ_bus_driver.sv
module univ_bus_driver #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         pass_en,
  input  logic         cap_clk,
  input  logic         drive_n,
  output logic [W-1:0] y_val,
  output logic [W-1:0] y_en,
  output logic [W-1:0] held_q
);
  // Named internal events, shared by all lanes.
  logic cap_rise;
  logic capture_mode;

  assign capture_mode = ~pass_en;

  ubd_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_clk),
    .rise   (cap_rise)
  );

  for (genvar i = 0; i < W; i++) begin : g_lane
    ubd_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .pass  (~capture_mode),
      .rise  (cap_rise),
      .d     (a_in[i]),
      .q     (held_q[i]),
      .y     (y_val[i])
    );
  end

  ubd_drive #(.W(W)) u_drive (
    .drive_n (drive_n),
    .en      (y_en)
  );
endmodule

// File: rtl/univ_bus_driver_chk.sv
module univ_bus_driver_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         pass_en,
  input logic         cap_clk,
  input logic         drive_n,
  input logic [W-1:0] y_val,
  input logic [W-1:0] y_en,
  input logic [W-1:0] held_q
);
  // Checker's own view of the strobe's previous level.
  logic seen_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_prev <= 1'b1;
    else        seen_prev <= cap_clk;
  end

  logic strobe_up;
  assign strobe_up = cap_clk && !seen_prev;

  p_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drive_n |-> (y_en == '0));

  p_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_n |-> (&y_en));

  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_en |-> (y_val == a_in));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_en && strobe_up) |=> (held_q == $past(a_in)));

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_en && !strobe_up) |=> $stable(held_q));

  p_show_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_en |-> (y_val == held_q));

  p_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_en && $past(pass_en) && $past(rst_n)) |-> (held_q == $past(a_in)));
endmodule

bind univ_bus_driver univ_bus_driver_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .pass_en (pass_en),
  .cap_clk (cap_clk),
  .drive_n (drive_n),
  .y_val   (y_val),
  .y_en    (y_en),
  .held_q  (held_q)
);

// File: tb/sim_univ_bus_driver.sv
module sim_univ_bus_driver;
  localparam int W = 18;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic         pass_en = 1'b0;
  logic         cap_clk = 1'b0;
  logic         drive_n = 1'b0;
  logic [W-1:0] y_val, y_en, held_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  univ_bus_driver #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .pass_en(pass_en),
    .cap_clk(cap_clk), .drive_n(drive_n), .y_val(y_val), .y_en(y_en),
    .held_q(held_q)
  );

  // Vector: {pass_en, cap_clk, drive_n, a_in[17:0], expected held_q[17:0]}
  localparam logic [38:0] VEC [NV] = '{
    {3'b000, 18'h3A5A5, 18'h00000},  // R8 cleared, R5 low strobe
    {3'b010, 18'h12345, 18'h12345},  // R4 strobe rise loads
    {3'b010, 18'h0FFFF, 18'h12345},  // R5 strobe held high
    {3'b000, 18'h2AAAA, 18'h12345},  // R5 strobe held low
    {3'b100, 18'h2AAAA, 18'h2AAAA},  // R3 transparent
    {3'b110, 18'h15555, 18'h15555},  // R3 strobe ignored
    {3'b010, 18'h3FFFF, 18'h15555},  // R6 fall with strobe high
    {3'b000, 18'h3FFFF, 18'h15555},  // R5 hold
    {3'b010, 18'h3FFFF, 18'h3FFFF},  // R4 load
    {3'b001, 18'h00001, 18'h3FFFF},  // R1 released, R7 kept
    {3'b011, 18'h00001, 18'h00001},  // R7 capture while released
    {3'b010, 18'h2BEEF, 18'h00001},  // R7 re-enabled shows held word
    {3'b100, 18'h0ABCD, 18'h0ABCD},  // R3 transparent
    {3'b000, 18'h31111, 18'h0ABCD},  // R6 fall with strobe low
    {3'b010, 18'h31111, 18'h31111}   // R4 load after low fall
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cap_clk = 1'b1;
    repeat (2) @(negedge clk);
    // R8: reset state, strobe high at release is no edge
    check("R8", held_q, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", held_q, '0);
    check("R2", y_en, '1);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      logic [W-1:0] exp_y, exp_en;
      v = VEC[i];
      pass_en = v[38];
      cap_clk = v[37];
      drive_n = v[36];
      a_in    = v[35:18];
      @(negedge clk);
      exp_y  = pass_en ? a_in : v[17:0];
      exp_en = drive_n ? '0 : '1;
      check($sformatf("R4/R5/R6/R7 store v%0d", i), held_q, v[17:0]);
      check($sformatf("R3/R5 view v%0d", i), y_val, exp_y);
      check($sformatf("R1/R2 enable v%0d", i), y_en, exp_en);
    end

    // R3: transparent output follows input within the cycle
    pass_en = 1'b1;
    drive_n = 1'b0;
    a_in = 18'h04321;
    #1 check("R3 same-cycle", y_val, 18'h04321);
    a_in = 18'h1F0F0;
    #1 check("R3 same-cycle", y_val, 18'h1F0F0);
    @(negedge clk);

    // R8: reset with a non-zero word stored
    pass_en = 1'b0;
    cap_clk = 1'b0;
    @(negedge clk);
    check("R8 pre", held_q, 18'h1F0F0);
    rst_n = 1'b0;
    #1 check("R8 cleared", held_q, '0);
    check("R8 view", y_val, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after", held_q, '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule